// File: doc/BRIEF.md
# Converter Host Bus Controller

This block is the digital side of a sampling converter that sits on a processor bus. The processor drives four active-low strobes: chip select, write, read and status select. A write with status select high starts a conversion. A fixed count of clock cycles stands in for the analog conversion time. When the count runs out, the controller copies a 13-bit signed result from `result_in` into an output latch. On the same edge it pulls the interrupt low and drops the wait-state line for one cycle. A write with status select low resets the control logic and abandons any conversion in progress.

All four strobes pass through a two-stage synchronizer. Edges are detected on the synchronized copies. A read with status select high returns the output latch. A read with status select low returns a two-bit status word. The processor may tie write and read together as one strobe. The falling edge of that strobe then starts a conversion and captures the result of the previous conversion.

Top module: `adc_host_ctrl`

## Requirements
- R1: While `rst_n` is low and after it is released, `int_n` is 1, `ready_out` is 1, `data_out` is 0, both status bits are 0 and the output latch holds 0.
- R2: A falling write with `cs_n` low and `stsel_n` high is a start. `CONV_CYCLES` clock edges after the edge that acts on the start, the latch takes `result_in`. A later data read returns that value.
- R3: When a conversion completes, `int_n` goes low and the data-ready status bit is set. If a read or write strobe is held low with `cs_n` low at that moment, `int_n` stays high and the data-ready bit stays 0, but the latch is still updated.
- R4: The falling edge of a read with `cs_n` low returns `int_n` to 1.
- R5: A start write returns `int_n` to 1 and restarts the conversion count.
- R6: A read with `stsel_n` low returns the status word: bit 0 is end-of-conversion, bit 1 is data-ready, and bits 12..2 are 0.
- R7: Both status bits are cleared by a data read, a status read (the read returns the values before the clear), a start write or a status write.
- R8: A falling write with `cs_n` and `stsel_n` both low aborts a running conversion: no completion follows, `int_n` stays high and the latch keeps its old value.
- R9: `ready_out` is low for exactly one cycle, the cycle in which the latch is updated, and is high at all other times.
- R10: A data read loads `data_out` with the latch as it stood at the read's falling edge. If the latch is updated while that data read is still held, `data_out` takes the new result on the same edge. A short combined write/read strobe therefore returns the previous conversion's result.
- R11: A strobe change applied between clock edges takes effect on the third rising edge after the change, because of the two synchronizer stages plus the edge detector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| stsel_n | input | 1 | Status select, active low |
| result_in | input | 13 | Converted value, 12 bits plus sign |
| data_out | output | 13 | Read data: the latch or the status word |
| int_n | output | 1 | Conversion-done interrupt, active low |
| ready_out | output | 1 | Wait-state request, low during a latch update |

## Verification
The bench aborts a conversion part way through. A controller that only clears its flags on abort would still load the latch and raise the interrupt later. The bench holds a combined strobe for longer than a conversion. A design that ignores the held strobe would raise an interrupt the processor never sees cleared. A design without the refresh would return stale data. The bench reads the status word twice in a row to expose two faults: a status bit that does not clear on read, and a read that returns the value after the clear rather than before it. It also counts the cycles from a pin change to the resulting output change, which exposes a missing or extra synchronizer stage.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;
  localparam int STAT_W = 2;
  localparam int NSTROBE = 4;
  localparam int IDX_CS = 0;
  localparam int IDX_WR = 1;
  localparam int IDX_RD = 2;
  localparam int IDX_ST = 3;

  typedef struct packed {
    logic sel;
    logic stat_mode;
    logic wr_low;
    logic rd_low;
    logic wr_fall;
    logic rd_fall;
  } bus_evt_t;
endpackage

// File: rtl/adc_strobe_sync.sv
module adc_strobe_sync #(
  parameter int N = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_n,
  output logic [N-1:0] lvl_n,
  output logic [N-1:0] fall
);
  for (genvar i = 0; i < N; i++) begin : g_line
    logic [STAGES-1:0] chain;
    logic              prev;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain <= '1;
        prev  <= 1'b1;
      end else begin
        chain <= {chain[STAGES-2:0], pin_n[i]};
        prev  <= chain[STAGES-1];
      end
    end
    assign lvl_n[i] = chain[STAGES-1];
    assign fall[i]  = prev & ~chain[STAGES-1];
  end
endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
  parameter int CONV_CYCLES = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  output logic busy,
  output logic done
);
  localparam int CNT_W = $clog2(CONV_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(CONV_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  assign done = busy && (cnt == '0) && !start && !abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (abort) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= CNT_TOP;
    end else if (done) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end

  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt <= CNT_TOP));
  assert_abort_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !busy);
endmodule

// File: rtl/adc_result_port.sv
module adc_result_port #(
  parameter int RES_W = 13
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            load,
  input  logic [RES_W-1:0]                result_in,
  input  logic                            capture,
  input  logic                            stat_mode,
  input  logic [adc_host_pkg::STAT_W-1:0] stat_word,
  input  logic                            refresh,
  output logic [RES_W-1:0]                data_out
);
  import adc_host_pkg::*;
  localparam int PAD_W = RES_W - STAT_W;

  logic [RES_W-1:0] latch_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q  <= '0;
      data_out <= '0;
    end else begin
      if (capture) data_out <= stat_mode ? {{PAD_W{1'b0}}, stat_word} : latch_q;
      if (load) begin
        latch_q <= result_in;
        if (refresh) data_out <= result_in;
      end
    end
  end

  assert_status_pad_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && stat_mode && !(load && refresh)) |=> (data_out[RES_W-1:STAT_W] == '0));
endmodule

// File: rtl/adc_host_ctrl.sv
module adc_host_ctrl #(
  parameter int RES_W = 13,
  parameter int CONV_CYCLES = 40,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             wr_n,
  input  logic             rd_n,
  input  logic             stsel_n,
  input  logic [RES_W-1:0] result_in,
  output logic [RES_W-1:0] data_out,
  output logic             int_n,
  output logic             ready_out
);
  import adc_host_pkg::*;

  logic [NSTROBE-1:0] pins_n, lvl_n, fall;
  bus_evt_t evt;
  logic start, abort, busy, done, hold_low;
  logic eoc_q, dry_q;

  assign pins_n[IDX_CS] = cs_n;
  assign pins_n[IDX_WR] = wr_n;
  assign pins_n[IDX_RD] = rd_n;
  assign pins_n[IDX_ST] = stsel_n;

  adc_strobe_sync #(.N(NSTROBE), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_n(pins_n), .lvl_n(lvl_n), .fall(fall));

  always_comb begin
    evt.sel       = !lvl_n[IDX_CS];
    evt.stat_mode = !lvl_n[IDX_ST];
    evt.wr_low    = !lvl_n[IDX_WR];
    evt.rd_low    = !lvl_n[IDX_RD];
    evt.wr_fall   = evt.sel && fall[IDX_WR];
    evt.rd_fall   = evt.sel && fall[IDX_RD];
  end

  assign start    = evt.wr_fall && !evt.stat_mode;
  assign abort    = evt.wr_fall && evt.stat_mode;
  assign hold_low = evt.sel && (evt.rd_low || evt.wr_low);

  adc_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .busy(busy), .done(done));

  adc_result_port #(.RES_W(RES_W)) u_port (
    .clk(clk), .rst_n(rst_n), .load(done), .result_in(result_in),
    .capture(evt.rd_fall), .stat_mode(evt.stat_mode), .stat_word({dry_q, eoc_q}),
    .refresh(evt.sel && evt.rd_low && !evt.stat_mode), .data_out(data_out));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_n     <= 1'b1;
      eoc_q     <= 1'b0;
      dry_q     <= 1'b0;
      ready_out <= 1'b1;
    end else begin
      ready_out <= !done;
      if (evt.rd_fall) begin
        int_n <= 1'b1;
        eoc_q <= 1'b0;
        dry_q <= 1'b0;
      end
      if (done) begin
        eoc_q <= 1'b1;
        if (!hold_low) begin
          int_n <= 1'b0;
          dry_q <= 1'b1;
        end
      end
      if (start || abort) begin
        int_n <= 1'b1;
        eoc_q <= 1'b0;
        dry_q <= 1'b0;
      end
    end
  end

  assert_ready_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_out |=> ready_out);
  assert_int_from_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_n) |-> $past(done));
  assert_read_clears_int_R4: assert property (@(posedge clk) disable iff (!rst_n)
    evt.rd_fall |=> int_n);
  assert_start_clears_int_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (int_n && busy));
endmodule

// File: tb/tb_adc_host_ctrl.sv
module tb_adc_host_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int RES_W = 13;
  localparam int CONV = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, stsel_n = 1'b1;
  logic [RES_W-1:0] result_in = '0;
  logic [RES_W-1:0] data_out;
  logic int_n, ready_out;

  int n_cmp = 0, n_bad = 0, rdy_lows = 0;
  bit live = 0, finished = 0;

  adc_host_ctrl #(.RES_W(RES_W), .CONV_CYCLES(CONV)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .stsel_n(stsel_n), .result_in(result_in), .data_out(data_out),
    .int_n(int_n), .ready_out(ready_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference: pin history as short delay lines, state as integers.
  logic [2:0] h_cs, h_wr, h_rd, h_st;
  int m_busy, m_cnt, m_eoc, m_dry, m_int, m_rdy;
  logic [RES_W-1:0] m_latch, m_dout;

  always @(posedge clk) begin
    if (!rst_n) begin
      h_cs = '1; h_wr = '1; h_rd = '1; h_st = '1;
      m_busy = 0; m_cnt = 0; m_eoc = 0; m_dry = 0; m_int = 1; m_rdy = 1;
      m_latch = '0; m_dout = '0;
    end else begin
      bit sel, smode, wlow, rlow, wf, rf, st, ab, dn;
      logic [RES_W-1:0] old_latch;
      sel = !h_cs[1]; smode = !h_st[1]; wlow = !h_wr[1]; rlow = !h_rd[1];
      wf = sel && h_wr[2] && !h_wr[1];
      rf = sel && h_rd[2] && !h_rd[1];
      st = wf && !smode; ab = wf && smode;
      dn = (m_busy != 0) && m_cnt == 0 && !st && !ab;
      old_latch = m_latch;
      m_rdy = 1;
      if (rf) begin
        m_dout = smode ? RES_W'({m_dry[0], m_eoc[0]}) : old_latch;
        m_int = 1; m_eoc = 0; m_dry = 0;
      end
      if (dn) begin
        m_latch = result_in; m_eoc = 1; m_rdy = 0; m_busy = 0;
        if (!(sel && (rlow || wlow))) begin m_int = 0; m_dry = 1; end
        if (sel && rlow && !smode) m_dout = result_in;
      end else if (ab) m_busy = 0;
      else if (st) begin m_busy = 1; m_cnt = CONV - 1; end
      else if (m_busy != 0) m_cnt = m_cnt - 1;
      if (st || ab) begin m_int = 1; m_eoc = 0; m_dry = 0; end
      h_cs = {h_cs[1:0], cs_n}; h_wr = {h_wr[1:0], wr_n};
      h_rd = {h_rd[1:0], rd_n}; h_st = {h_st[1:0], stsel_n};
    end
  end

  task automatic check(input logic [RES_W-1:0] act, input logic [RES_W-1:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (live && rst_n) begin
      if (ready_out === 1'b0) rdy_lows++;
      check(RES_W'(int_n), RES_W'(m_int[0]), "R3/R4/R5 int_n");
      check(RES_W'(ready_out), RES_W'(m_rdy[0]), "R9 ready_out");
      check(data_out, m_dout, "R10/R11 data_out");
    end
  end

  task automatic bus_op(input logic st_low, input logic w, input logic r, input int hold);
    @(negedge clk);
    cs_n = 1'b0; stsel_n = !st_low; wr_n = !w; rd_n = !r;
    repeat (hold) @(negedge clk);
    wr_n = 1'b1; rd_n = 1'b1;
    @(negedge clk);
    cs_n = 1'b1; stsel_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    int base;
    idle(3);
    check(RES_W'(int_n), 13'd1, "R1 int_n in reset");
    check(RES_W'(ready_out), 13'd1, "R1 ready in reset");
    @(negedge clk); rst_n = 1'b1; live = 1;
    idle(2);
    check(data_out, 13'd0, "R1 data after reset");

    // Normal conversion, status reads, data read.
    result_in = 13'h1ABC; base = rdy_lows;
    bus_op(1'b0, 1'b1, 1'b0, 2);
    idle(CONV + 5);
    check(RES_W'(int_n), 13'd0, "R3 int asserted on completion");
    check(RES_W'(rdy_lows - base), 13'd1, "R9 single wait-state cycle");
    bus_op(1'b1, 1'b0, 1'b1, 2);
    check(data_out, 13'h0003, "R6 status word after completion");
    check(RES_W'(int_n), 13'd1, "R4 read releases int");
    bus_op(1'b1, 1'b0, 1'b1, 2);
    check(data_out, 13'h0000, "R7 status cleared by status read");
    bus_op(1'b0, 1'b0, 1'b1, 2);
    check(data_out, 13'h1ABC, "R2 latch holds result");

    // Abort part way through.
    result_in = 13'h0555; base = rdy_lows;
    bus_op(1'b0, 1'b1, 1'b0, 2);
    idle(10);
    bus_op(1'b1, 1'b1, 1'b0, 2);
    idle(CONV + 10);
    check(RES_W'(int_n), 13'd1, "R8 no interrupt after abort");
    check(RES_W'(rdy_lows - base), 13'd0, "R8 no latch update after abort");
    bus_op(1'b0, 1'b0, 1'b1, 2);
    check(data_out, 13'h1ABC, "R8 latch unchanged by abort");

    // Start write releases a pending interrupt.
    result_in = 13'h0F0F;
    bus_op(1'b0, 1'b1, 1'b0, 2);
    idle(CONV + 5);
    check(RES_W'(int_n), 13'd0, "R3 int low before restart");
    bus_op(1'b0, 1'b1, 1'b0, 2);
    check(RES_W'(int_n), 13'd1, "R5 start clears int");
    idle(CONV + 5);
    bus_op(1'b0, 1'b0, 1'b1, 2);
    check(data_out, 13'h0F0F, "R2 result after restart");

    // Short combined strobe returns the previous result.
    result_in = 13'h1234;
    bus_op(1'b0, 1'b1, 1'b1, 3);
    check(data_out, 13'h0F0F, "R10 combined strobe gives previous result");
    idle(CONV + 5);
    check(RES_W'(int_n), 13'd0, "R3 int after combined start");
    bus_op(1'b0, 1'b0, 1'b1, 2);
    check(data_out, 13'h1234, "R2 combined conversion result");

    // Combined strobe held past the conversion time.
    result_in = 13'h0321;
    @(negedge clk);
    cs_n = 1'b0; stsel_n = 1'b1; wr_n = 1'b0; rd_n = 1'b0;
    idle(CONV + 10);
    check(data_out, 13'h0321, "R10 refresh while strobe held");
    check(RES_W'(int_n), 13'd1, "R3 int suppressed while strobe held");
    wr_n = 1'b1; rd_n = 1'b1;
    @(negedge clk); cs_n = 1'b1;
    idle(4);
    bus_op(1'b1, 1'b0, 1'b1, 2);
    check(data_out, 13'h0001, "R6 end-of-conversion set without data-ready");

    // Synchronizer latency: status read showed 0x0001; now a data read.
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0;
    idle(2);
    check(data_out, 13'h0001, "R11 no effect after two edges");
    idle(1);
    check(data_out, 13'h0321, "R11 effect on third edge");
    rd_n = 1'b1; @(negedge clk); cs_n = 1'b1;
    idle(5);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule